// File: doc/BRIEF.md
# Codec Input Frame Assembler

This block produces the serial frame that a codec sends back to its controller on the input data line of a five-wire audio link. Each frame is 256 bit-clock cycles long. It opens with a 16-bit tag slot and continues with twelve 20-bit slots. The tag slot holds a ready flag and one valid tag per data slot. Slots 1 and 2 answer a register read. Slots 3 to 11 carry stereo capture samples. Slot 12 reports the general-purpose pin levels and a wake/interrupt flag.

A command decoder, which lies outside the block, presents each decoded register command as a one-cycle strobe that carries its index, direction and read value. The block keeps the latest command of the current frame pending. It answers a read in the frame that follows, and only in that frame. All other inputs are taken as a snapshot when a frame starts. A frame starts at the bit-clock rising edge where `sync` is first seen high after being low. The snapshot is then shifted out MSB first, one bit per rising edge.

Top module: `aclink_in_frame`

## Requirements
- R1: A frame begins at the rising `bitClk` edge where `sync` is sampled high after being sampled low. That edge drives frame bit 255 (tag-slot bit 15) onto `sdataOut`. Each following rising edge drives the next lower bit. The layout is the 16-bit tag slot in bits 255:240, then slot s (1..12) in bits 239-20*(s-1) down to 220-20*(s-1).
- R2: Tag-slot bit 15 equals `codecReady` sampled at frame start. Tag-slot bit 15-s is the valid tag of slot s. Tag-slot bits 2:0 are zero.
- R3: If a read command (`cmdStrobe` with `cmdRead`=1) is the last command in frame N, then frame N+1 sets the tags of slots 1 and 2. In that frame, slot 1 holds the index in bits 18:12, with bit 19 and bits 11:0 zero. Slot 2 holds the read value in bits 19:4, with bits 3:0 zero.
- R4: If the last command of a frame is a write (`cmdRead`=0), the next frame clears the tags of slots 1 and 2 and drives both slots as zero.
- R5: Only the last command of a frame counts. A read is answered in exactly one frame; the frame after it carries no echo unless another read arrived.
- R6: A command strobed at the same edge as a frame start does not affect that frame. It is answered in the following frame.
- R7: When `capValid` is set, `capLeft` and `capRight` go into bits 19:2 of a slot pair chosen by `captureMode`, with bits 1:0 zero and both tags set. The pairs are: 0 gives slots 3/4, 1 gives 7/8, 2 gives 6/9 and 3 gives 10/11. All other capture slots, and both slots when `capValid` is clear, are zero with their tags clear.
- R8: When `gpioValid` is set, slot 12 holds `gpioState` (pins 8 to 3, MSB first) in bits 19:14 and `gpioIrq` in bit 0, with bits 13:1 zero and its tag set. Otherwise slot 12 and its tag are zero.
- R9: Frame contents are fixed at frame start. Input changes during the frame do not alter the bits being shifted.
- R10: `sdataOut` is 0 out of reset and from the 257th edge after a frame start until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame alignment input; rising level starts a frame |
| cmdStrobe | input | 1 | One-cycle strobe of a decoded register command |
| cmdRead | input | 1 | 1 = read command, 0 = write command |
| cmdIndex | input | 7 | Register index of the command |
| cmdData | input | 16 | Register value to return for a read |
| codecReady | input | 1 | Ready flag placed in tag-slot bit 15 |
| captureMode | input | 2 | Selects the capture slot pair |
| capValid | input | 1 | Capture samples are valid |
| capLeft | input | 18 | Left capture sample, two's complement |
| capRight | input | 18 | Right capture sample, two's complement |
| gpioValid | input | 1 | Slot 12 is valid |
| gpioState | input | 6 | Pin levels, pins 8 down to 3 |
| gpioIrq | input | 1 | Wake/interrupt event flag |
| sdataOut | output | 1 | Serial frame output |

## Verification
A stale or doubled pending-read register shows up within one frame. It appears as an echo in slot 1 and slot 2 in the wrong frame, or as an echo that repeats in two frames. A bit counter that is off by one shifts every field of the frame. It also leaves a nonzero bit on the line at the 257th bit time, so a single frame exposes it. A slot-mapping fault puts capture data or a set tag in the wrong 20-bit window of the very frame in which it occurs.

// File: rtl/aclink_in_pkg.sv
package aclink_in_pkg;
  localparam int SLOT0_W   = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int FRAME_W   = SLOT0_W + SLOT_W * NUM_SLOTS;
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  localparam int IDX_W     = 7;
  localparam int REG_W     = 16;
  localparam int SAMPLE_W  = 18;
  localparam int GPIO_W    = 6;
  localparam int MODE_W    = 2;
  localparam int CAP_FIRST = 3;
  localparam int CAP_LAST  = 11;
  localparam int GPIO_SLOT = 12;

  typedef struct packed {
    logic loadFrame;
    logic shiftEn;
  } strobe_t;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] index;
    logic [REG_W-1:0] data;
  } rdResp_t;

  // MSB position of slot s inside the frame vector (slot 0 is the tag slot)
  function automatic int slotMsb(int s);
    return (s == 0) ? FRAME_W - 1 : FRAME_W - 1 - SLOT0_W - SLOT_W * (s - 1);
  endfunction

  function automatic int leftSlotOf(logic [MODE_W-1:0] m);
    case (m)
      2'd0:    return 3;
      2'd1:    return 7;
      2'd2:    return 6;
      default: return 10;
    endcase
  endfunction

  function automatic int rightSlotOf(logic [MODE_W-1:0] m);
    case (m)
      2'd0:    return 4;
      2'd1:    return 8;
      2'd2:    return 9;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/aclink_in_ctrl.sv
module aclink_in_ctrl
  import aclink_in_pkg::*;
(
  input  logic             bitClk,
  input  logic             rstN,
  input  logic             sync,
  input  logic             cmdStrobe,
  input  logic             cmdRead,
  input  logic [IDX_W-1:0] cmdIndex,
  input  logic [REG_W-1:0] cmdData,
  output strobe_t          strobe,
  output rdResp_t          resp
);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_W);

  logic             syncQ;
  logic             frameStart;
  logic [CNT_W-1:0] bitCnt;
  logic             pendValid;
  logic [IDX_W-1:0] pendIndex;
  logic [REG_W-1:0] pendData;

  assign frameStart = sync & ~syncQ;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 1'b0;
      bitCnt <= CNT_END;
    end else begin
      syncQ <= sync;
      if (frameStart)
        bitCnt <= CNT_W'(1);
      else if (bitCnt < CNT_END)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  // one pending entry; the newest command of a frame replaces older ones
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendIndex <= '0;
      pendData  <= '0;
    end else if (cmdStrobe) begin
      pendValid <= cmdRead;
      pendIndex <= cmdIndex;
      pendData  <= cmdData;
    end else if (frameStart) begin
      pendValid <= 1'b0;
    end
  end

  always_comb begin
    strobe.loadFrame = frameStart;
    strobe.shiftEn   = ~frameStart & (bitCnt < CNT_END);
    resp.valid       = pendValid;
    resp.index       = pendIndex;
    resp.data        = pendData;
  end
endmodule

// File: rtl/aclink_in_datapath.sv
module aclink_in_datapath
  import aclink_in_pkg::*;
(
  input  logic                bitClk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  rdResp_t             resp,
  input  logic                codecReady,
  input  logic [MODE_W-1:0]   captureMode,
  input  logic                capValid,
  input  logic [SAMPLE_W-1:0] capLeft,
  input  logic [SAMPLE_W-1:0] capRight,
  input  logic                gpioValid,
  input  logic [GPIO_W-1:0]   gpioState,
  input  logic                gpioIrq,
  output logic                sdataOut
);
  localparam int IDX_PAD  = SLOT_W - 1 - IDX_W;
  localparam int REG_PAD  = SLOT_W - REG_W;
  localparam int CAP_PAD  = SLOT_W - SAMPLE_W;
  localparam int GPIO_PAD = SLOT_W - GPIO_W - 1;

  logic [SLOT_W-1:0]    slotData [1:NUM_SLOTS];
  logic [NUM_SLOTS:1]   tagVec;
  logic [FRAME_W-1:0]   frameBits;
  logic [FRAME_W-1:0]   shiftReg;
  int                   leftSel;
  int                   rightSel;

  assign leftSel  = leftSlotOf(captureMode);
  assign rightSel = rightSlotOf(captureMode);

  always_comb begin
    for (int s = 1; s <= NUM_SLOTS; s++) begin
      slotData[s] = '0;
      tagVec[s]   = 1'b0;
    end
    if (resp.valid) begin
      tagVec[1]   = 1'b1;
      tagVec[2]   = 1'b1;
      slotData[1] = {1'b0, resp.index, {IDX_PAD{1'b0}}};
      slotData[2] = {resp.data, {REG_PAD{1'b0}}};
    end
    for (int s = CAP_FIRST; s <= CAP_LAST; s++) begin
      if (capValid && s == leftSel) begin
        tagVec[s]   = 1'b1;
        slotData[s] = {capLeft, {CAP_PAD{1'b0}}};
      end else if (capValid && s == rightSel) begin
        tagVec[s]   = 1'b1;
        slotData[s] = {capRight, {CAP_PAD{1'b0}}};
      end
    end
    if (gpioValid) begin
      tagVec[GPIO_SLOT]   = 1'b1;
      slotData[GPIO_SLOT] = {gpioState, {GPIO_PAD{1'b0}}, gpioIrq};
    end
  end

  always_comb begin
    frameBits = '0;
    frameBits[FRAME_W-1] = codecReady;
    for (int s = 1; s <= NUM_SLOTS; s++) begin
      frameBits[FRAME_W-1-s]          = tagVec[s];
      frameBits[slotMsb(s) -: SLOT_W] = slotData[s];
    end
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdataOut <= 1'b0;
    end else if (strobe.loadFrame) begin
      sdataOut <= frameBits[FRAME_W-1];
      shiftReg <= {frameBits[FRAME_W-2:0], 1'b0};
    end else if (strobe.shiftEn) begin
      sdataOut <= shiftReg[FRAME_W-1];
      shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
    end else begin
      sdataOut <= 1'b0;
    end
  end
endmodule

// File: rtl/aclink_in_frame.sv
module aclink_in_frame
  import aclink_in_pkg::*;
(
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                sync,
  input  logic                cmdStrobe,
  input  logic                cmdRead,
  input  logic [IDX_W-1:0]    cmdIndex,
  input  logic [REG_W-1:0]    cmdData,
  input  logic                codecReady,
  input  logic [MODE_W-1:0]   captureMode,
  input  logic                capValid,
  input  logic [SAMPLE_W-1:0] capLeft,
  input  logic [SAMPLE_W-1:0] capRight,
  input  logic                gpioValid,
  input  logic [GPIO_W-1:0]   gpioState,
  input  logic                gpioIrq,
  output logic                sdataOut
);
  strobe_t strobe;
  rdResp_t resp;

  aclink_in_ctrl ctrl_i (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .sync     (sync),
    .cmdStrobe(cmdStrobe),
    .cmdRead  (cmdRead),
    .cmdIndex (cmdIndex),
    .cmdData  (cmdData),
    .strobe   (strobe),
    .resp     (resp)
  );

  aclink_in_datapath dp_i (
    .bitClk     (bitClk),
    .rstN       (rstN),
    .strobe     (strobe),
    .resp       (resp),
    .codecReady (codecReady),
    .captureMode(captureMode),
    .capValid   (capValid),
    .capLeft    (capLeft),
    .capRight   (capRight),
    .gpioValid  (gpioValid),
    .gpioState  (gpioState),
    .gpioIrq    (gpioIrq),
    .sdataOut   (sdataOut)
  );
endmodule

// File: rtl/aclink_in_frame_chk.sv
module aclink_in_frame_chk
  import aclink_in_pkg::*;
(
  input logic bitClk,
  input logic rstN,
  input logic sync,
  input logic sdataOut
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(FRAME_W);

  // index of the frame bit currently on the line (0 = first bit), IDLE when none
  logic [CNT_W-1:0] pos;
  logic             seenSync;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      seenSync <= 1'b0;
      pos      <= IDLE;
    end else begin
      seenSync <= sync;
      if (sync && !seenSync)
        pos <= '0;
      else if (pos < IDLE)
        pos <= pos + 1'b1;
    end
  end

  assert_idle_low_R10: assert property (@(posedge bitClk) disable iff (!rstN)
    (pos == IDLE) |-> (sdataOut == 1'b0));

  assert_tag_pad_zero_R2: assert property (@(posedge bitClk) disable iff (!rstN)
    (pos >= CNT_W'(13) && pos <= CNT_W'(15)) |-> (sdataOut == 1'b0));

  // slot 1 bit 19 and bits 11:0 are zero
  assert_index_pad_zero_R3: assert property (@(posedge bitClk) disable iff (!rstN)
    (pos == CNT_W'(16) || (pos >= CNT_W'(24) && pos <= CNT_W'(35))) |-> (sdataOut == 1'b0));

  assert_data_pad_zero_R3: assert property (@(posedge bitClk) disable iff (!rstN)
    (pos >= CNT_W'(52) && pos <= CNT_W'(55)) |-> (sdataOut == 1'b0));

  assert_sample_pad_zero_R7: assert property (@(posedge bitClk) disable iff (!rstN)
    (pos >= CNT_W'(56) && pos < CNT_W'(236) && ((pos - CNT_W'(16)) % CNT_W'(20)) >= CNT_W'(18))
      |-> (sdataOut == 1'b0));

  assert_gpio_pad_zero_R8: assert property (@(posedge bitClk) disable iff (!rstN)
    (pos >= CNT_W'(242) && pos <= CNT_W'(254)) |-> (sdataOut == 1'b0));
endmodule

bind aclink_in_frame aclink_in_frame_chk chk_i (
  .bitClk  (bitClk),
  .rstN    (rstN),
  .sync    (sync),
  .sdataOut(sdataOut)
);

// File: tb/aclink_in_frame_tb_top.sv
module aclink_in_frame_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  typedef struct {
    logic [255:0] bits;
    string        note;
  } expItem_t;

  logic        bitClk = 1'b0;
  logic        rstN;
  logic        sync;
  logic        cmdStrobe;
  logic        cmdRead;
  logic [6:0]  cmdIndex;
  logic [15:0] cmdData;
  logic        codecReady;
  logic [1:0]  captureMode;
  logic        capValid;
  logic [17:0] capLeft;
  logic [17:0] capRight;
  logic        gpioValid;
  logic [5:0]  gpioState;
  logic        gpioIrq;
  logic        sdataOut;

  int nChecks = 0;
  int nErrors = 0;
  int framesPushed = 0;
  int framesSeen = 0;
  bit finished = 0;

  expItem_t expQ[$];

  // bench model of the pending command
  logic        mPend = 1'b0;
  logic [6:0]  mIdx = '0;
  logic [15:0] mData = '0;

  always #(CLK_PERIOD / 2) bitClk = ~bitClk;

  aclink_in_frame dut_i (
    .bitClk(bitClk), .rstN(rstN), .sync(sync),
    .cmdStrobe(cmdStrobe), .cmdRead(cmdRead), .cmdIndex(cmdIndex), .cmdData(cmdData),
    .codecReady(codecReady), .captureMode(captureMode), .capValid(capValid),
    .capLeft(capLeft), .capRight(capRight),
    .gpioValid(gpioValid), .gpioState(gpioState), .gpioIrq(gpioIrq),
    .sdataOut(sdataOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  function automatic logic [255:0] buildFrame(
      logic ready, logic cV, logic [1:0] mode, logic [17:0] cL, logic [17:0] cR,
      logic gV, logic [5:0] gS, logic irq, logic pend, logic [6:0] idx, logic [15:0] dat);
    logic [255:0] f;
    int ls;
    int rs;
    f = '0;
    ls = (mode == 2'd0) ? 3 : (mode == 2'd1) ? 7 : (mode == 2'd2) ? 6 : 10;
    rs = (mode == 2'd0) ? 4 : (mode == 2'd1) ? 8 : (mode == 2'd2) ? 9 : 11;
    f[255] = ready;
    if (pend) begin
      f[254] = 1'b1;
      f[253] = 1'b1;
      f[239 -: 20] = {1'b0, idx, 12'h000};
      f[219 -: 20] = {dat, 4'h0};
    end
    if (cV) begin
      f[255 - ls] = 1'b1;
      f[255 - rs] = 1'b1;
      f[239 - 20 * (ls - 1) -: 20] = {cL, 2'b00};
      f[239 - 20 * (rs - 1) -: 20] = {cR, 2'b00};
    end
    if (gV) begin
      f[243] = 1'b1;
      f[19:0] = {gS, 13'h0, irq};
    end
    return f;
  endfunction

  task automatic issueCmd(logic rd, logic [6:0] idx, logic [15:0] dat);
    @(negedge bitClk);
    cmdStrobe = 1'b1; cmdRead = rd; cmdIndex = idx; cmdData = dat;
    @(negedge bitClk);
    cmdStrobe = 1'b0;
    mPend = rd; mIdx = idx; mData = dat;
  endtask

  // driver: pushes the expected frame and raises sync
  task automatic startFrame(
      string note, logic ready, logic cV, logic [1:0] mode, logic [17:0] cL, logic [17:0] cR,
      logic gV, logic [5:0] gS, logic irq,
      logic withCmd, logic cRd, logic [6:0] cIdx, logic [15:0] cDat);
    expItem_t it;
    it.bits = buildFrame(ready, cV, mode, cL, cR, gV, gS, irq, mPend, mIdx, mData);
    it.note = note;
    expQ.push_back(it);
    framesPushed++;
    @(negedge bitClk);
    codecReady = ready; capValid = cV; captureMode = mode; capLeft = cL; capRight = cR;
    gpioValid = gV; gpioState = gS; gpioIrq = irq;
    sync = 1'b1;
    if (withCmd) begin
      cmdStrobe = 1'b1; cmdRead = cRd; cmdIndex = cIdx; cmdData = cDat;
    end
    @(negedge bitClk);
    sync = 1'b0;
    cmdStrobe = 1'b0;
    mPend = withCmd ? cRd : 1'b0;
    if (withCmd) begin mIdx = cIdx; mData = cDat; end
    // R9: scramble every snapshot input during the frame
    codecReady = ~ready; capValid = ~cV; captureMode = ~mode; capLeft = ~cL; capRight = ~cR;
    gpioValid = ~gV; gpioState = ~gS; gpioIrq = ~irq;
  endtask

  task automatic finishFrame();
    wait (framesSeen == framesPushed);
    repeat (4) @(negedge bitClk);
  endtask

  // monitor: collects each frame after a sync rise and compares it slot by slot
  initial begin
    logic prevS;
    logic [255:0] got;
    expItem_t it;
    prevS = 1'b0;
    forever begin
      @(posedge bitClk);
      if (rstN === 1'b1 && sync === 1'b1 && prevS === 1'b0) begin
        for (int k = 0; k < 256; k++) begin
          @(negedge bitClk);
          got[255 - k] = sdataOut;
        end
        @(negedge bitClk);
        check("R10 line low after frame", {31'd0, sdataOut}, 32'd0);
        if (expQ.size() == 0) begin
          check("R1 unexpected frame", 32'd1, 32'd0);
        end else begin
          it = expQ.pop_front();
          check({"R1 R2 tag slot ", it.note}, {16'd0, got[255:240]}, {16'd0, it.bits[255:240]});
          for (int s = 1; s <= 12; s++) begin
            string req;
            if (s <= 2) req = {it.note, " register slot"};
            else if (s <= 11) req = {"R7 R9 capture slot ", it.note};
            else req = {"R8 gpio slot ", it.note};
            check($sformatf("%s %0d", req, s), {12'd0, got[239 - 20 * (s - 1) -: 20]},
                  {12'd0, it.bits[239 - 20 * (s - 1) -: 20]});
          end
        end
        framesSeen++;
        prevS = 1'b0;
      end else begin
        prevS = sync;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge bitClk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; sync = 1'b0; cmdStrobe = 1'b0; cmdRead = 1'b0; cmdIndex = '0; cmdData = '0;
    codecReady = 1'b0; captureMode = '0; capValid = 1'b0; capLeft = '0; capRight = '0;
    gpioValid = 1'b0; gpioState = '0; gpioIrq = 1'b0;
    repeat (5) @(negedge bitClk);
    check("R10 reset output", {31'd0, sdataOut}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge bitClk);
    check("R10 idle after reset", {31'd0, sdataOut}, 32'd0);

    // R2: empty frame, ready low, nothing valid
    startFrame("R2 empty", 1'b0, 1'b0, 2'd0, 18'h0, 18'h0, 1'b0, 6'h0, 1'b0, 1'b0, 1'b0, 7'h0, 16'h0);
    issueCmd(1'b1, 7'h2C, 16'hBEEF);
    finishFrame();

    // R3: read answered in the next frame; mode 0 capture
    startFrame("R3 read echo", 1'b1, 1'b1, 2'd0, 18'h2_0001, 18'h1_FFFE, 1'b1, 6'b101001, 1'b0,
               1'b0, 1'b0, 7'h0, 16'h0);
    issueCmd(1'b0, 7'h02, 16'hAAAA);
    finishFrame();

    // R4: write gives no echo; mode 1, irq set
    startFrame("R4 write no echo", 1'b1, 1'b1, 2'd1, 18'h3_FFFF, 18'h0_0001, 1'b1, 6'b010110, 1'b1,
               1'b0, 1'b0, 7'h0, 16'h0);
    issueCmd(1'b1, 7'h11, 16'h5555);
    issueCmd(1'b0, 7'h22, 16'h0F0F);
    finishFrame();

    // R5: read then write in one frame, write wins; mode 2
    startFrame("R5 last write wins", 1'b1, 1'b1, 2'd2, 18'h1_2345, 18'h2_ABCD, 1'b0, 6'h3F, 1'b1,
               1'b0, 1'b0, 7'h0, 16'h0);
    issueCmd(1'b0, 7'h33, 16'h1111);
    issueCmd(1'b1, 7'h7F, 16'h1234);
    finishFrame();

    // R5: write then read, read wins; R6: command at the frame start edge waits
    startFrame("R5 last read wins", 1'b0, 1'b1, 2'd3, 18'h0_8000, 18'h3_0000, 1'b1, 6'b000001, 1'b1,
               1'b1, 1'b1, 7'h05, 16'h00F0);
    finishFrame();

    // R6: the command given with the previous sync is answered here
    startFrame("R6 same edge command", 1'b1, 1'b0, 2'd1, 18'h1_5A5A, 18'h2_A5A5, 1'b0, 6'h0, 1'b0,
               1'b0, 1'b0, 7'h0, 16'h0);
    finishFrame();

    // R5: an answered read does not repeat
    startFrame("R5 single echo", 1'b1, 1'b1, 2'd0, 18'h0_0F0F, 18'h3_F0F0, 1'b1, 6'b110011, 1'b0,
               1'b0, 1'b0, 7'h0, 16'h0);
    finishFrame();

    check("R1 all frames seen", framesSeen, framesPushed);
    finishRun();
  end
endmodule